// File: doc/BRIEF.md
# RTC Trimmed Second Prescaler

The block sits between a crystal oscillator tick (a one-cycle clock enable at a nominal 32768 per second) and the time-of-day counters. It divides the tick stream down to a once-per-second pulse and a once-per-minute marker. It also applies a signed digital trim: inside a repeating 64-minute cycle, the first second of each of the first 2×N minutes is either lengthened or shortened. N is the 5-bit trim magnitude. Each trim step therefore corrects the rate by a fixed parts-per-million amount.

A free-running untrimmed divider, separate from the second divider, produces two outputs. The first is a 512 Hz square wave for frequency measurement, gated by a test enable. The second is a 32 Hz pulse for downstream timers. Neither depends on the trim setting, so the measured test frequency shows the raw crystal error. A stop control freezes every counter while the oscillator is held off.

All rates are parameters. The defaults give 32768 ticks per second, 60 seconds per minute, a +128-tick long second, a −256-tick short second, a 32-tick test half period and a 1024-tick 32 Hz period.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is asserted, and after reset until the first tick completes a period, sec_tick, min_tick, tick32 and ftest_wave are 0. The trim setting latched at reset is magnitude 0, which means no trim.
- R2: An untrimmed second lasts BASE_DIV effective ticks, where an effective tick is osc_tick=1 with osc_stop=0. sec_tick is a one-cycle pulse in the clock cycle after the tick that ends the second. min_tick pulses together with the sec_tick of the last of SEC_PER_MIN seconds, and never without it.
- R3: With the latched sign 0 (slow down) and magnitude N, second 0 of minute indices 0 to 2N−1 of the cycle lasts BASE_DIV+LONG_EXTRA effective ticks.
- R4: With the latched sign 1 (speed up) and magnitude N, second 0 of minute indices 0 to 2N−1 lasts BASE_DIV−SHORT_CUT effective ticks.
- R5: The minute index counts 0 to 63, advances once per minute and wraps from 63 to 0. Minutes with an index of 2N or more, and all seconds other than second 0, last BASE_DIV ticks.
- R6: cal_mag and cal_pos are sampled only at a minute boundary, in the cycle of the tick that ends the minute. Changes in the middle of a minute do not alter any second of that minute.
- R7: ftest_wave equals ftest_en ANDed with bit log2(FTEST_HALF) of the count of effective ticks since reset. It therefore toggles every FTEST_HALF ticks, whatever the trim, and is 0 when the test is disabled. FTEST_HALF and T32_DIV are powers of two, with FTEST_HALF < T32_DIV.
- R8: tick32 is a one-cycle pulse in the cycle after every T32_DIV-th effective tick since reset, regardless of trim.
- R9: While osc_stop is 1, osc_tick is ignored. No counter moves, and sec_tick, min_tick and tick32 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick, one clock enable per oscillator cycle |
| osc_stop | input | 1 | 1 holds the oscillator stopped; 0 (default) runs it |
| cal_mag | input | CAL_W | Trim magnitude N, 0 to 31 |
| cal_pos | input | 1 | Trim sign: 1 speeds up (short second), 0 slows down (long second) |
| ftest_en | input | 1 | Enables the untrimmed test square wave |
| sec_tick | output | 1 | One-cycle pulse per trimmed second |
| min_tick | output | 1 | One-cycle pulse with the last second of each minute |
| ftest_wave | output | 1 | Untrimmed test square wave, 0 when disabled |
| tick32 | output | 1 | One-cycle pulse per T32_DIV effective ticks |

## Verification
The assertions assume four things about the inputs:
- osc_tick is sampled once per clock as a plain enable.
- A stopped oscillator is expressed only through osc_stop.
- Any input may change on any cycle.
- The parameters keep SHORT_CUT below BASE_DIV, and use powers of two for the raw divider.

The bench drives all inputs at the falling edge. It shrinks the divider parameters so that more than one full 64-minute cycle fits in the run. It draws tick gaps, stop bursts, test-enable changes and trim changes at random, including changes in the middle of a minute. It only ever uses the legal parameter set.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    // Length chosen for the second currently being counted
    typedef enum logic [1:0] {
        LEN_NOMINAL = 2'd0,
        LEN_LONG    = 2'd1,
        LEN_SHORT   = 2'd2
    } len_sel_e;
endpackage

// File: rtl/rtc_raw_div.sv
module rtc_raw_div #(
    parameter int T32_DIV    = 1024,
    parameter int FTEST_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic ftest_en,
    output logic ftest_wave,
    output logic tick32
);
    localparam int RAW_W    = $clog2(T32_DIV);
    localparam int HALF_BIT = $clog2(FTEST_HALF);

    typedef struct packed {
        logic [RAW_W-1:0] cnt;
        logic             wave;
        logic             t32;
    } raw_st_t;

    raw_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.t32 = 1'b0;
        if (tick_en) begin
            if (st_q.cnt == RAW_W'(T32_DIV - 1)) begin
                st_d.cnt = '0;
                st_d.t32 = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.wave = ftest_en & st_d.cnt[HALF_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ftest_wave = st_q.wave;
    assign tick32     = st_q.t32;

    // R7: with no tick and a steady enable the wave does not move
    p_wave_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && $stable(ftest_en)) |=> $stable(ftest_wave));

    // R8: the 32 Hz pulse is never two cycles wide
    p_t32_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick32 |=> !tick32);
endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
    import rtc_trim_pkg::*;
#(
    parameter int BASE_DIV   = 32768,
    parameter int LONG_EXTRA = 128,
    parameter int SHORT_CUT  = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_en,
    input  len_sel_e len_sel,
    output logic     sec_wrap
);
    localparam int CNT_W    = $clog2(BASE_DIV + LONG_EXTRA);
    localparam int LAST_MAX = BASE_DIV + LONG_EXTRA - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        unique case (len_sel)
            LEN_LONG:  last_val = CNT_W'(BASE_DIV + LONG_EXTRA - 1);
            LEN_SHORT: last_val = CNT_W'(BASE_DIV - SHORT_CUT - 1);
            default:   last_val = CNT_W'(BASE_DIV - 1);
        endcase
        sec_wrap = tick_en && (cnt_q == last_val);
        cnt_d    = cnt_q;
        if (tick_en) cnt_d = sec_wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the count never passes the longest allowed second
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LAST_MAX));

    // R6: the selected length only changes across a second boundary
    p_len_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_wrap |=> $stable(len_sel));
endmodule

// File: rtl/rtc_cal_cycle.sv
module rtc_cal_cycle
    import rtc_trim_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_wrap,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output len_sel_e         len_sel,
    output logic             min_wrap
);
    localparam int SIDX_W = ($clog2(SEC_PER_MIN) < 1) ? 1 : $clog2(SEC_PER_MIN);
    localparam int MIDX_W = CAL_W + 1;

    typedef struct packed {
        logic [SIDX_W-1:0] sec_idx;
        logic [MIDX_W-1:0] min_idx;
        logic [CAL_W-1:0]  mag;
        logic              pos;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        min_wrap = sec_wrap && (st_q.sec_idx == SIDX_W'(SEC_PER_MIN - 1));
        if (sec_wrap) begin
            if (min_wrap) begin
                st_d.sec_idx = '0;
                st_d.min_idx = st_q.min_idx + 1'b1;
                st_d.mag     = cal_mag;
                st_d.pos     = cal_pos;
            end else begin
                st_d.sec_idx = st_q.sec_idx + 1'b1;
            end
        end
        len_sel = LEN_NOMINAL;
        if ((st_q.sec_idx == '0) && (st_q.min_idx < {st_q.mag, 1'b0}))
            len_sel = st_q.pos ? LEN_SHORT : LEN_LONG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the latched trim holds for the whole minute
    p_cal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !min_wrap |=> ($stable(st_q.mag) && $stable(st_q.pos)));

    // R5: the minute index moves only at a minute boundary
    p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !min_wrap |=> $stable(st_q.min_idx));
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int BASE_DIV    = 32768,
    parameter int LONG_EXTRA  = 128,
    parameter int SHORT_CUT   = 256,
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5,
    parameter int FTEST_HALF  = 32,
    parameter int T32_DIV     = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             osc_stop,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             ftest_en,
    output logic             sec_tick,
    output logic             min_tick,
    output logic             ftest_wave,
    output logic             tick32
);
    typedef struct packed {
        logic sec;
        logic min;
    } out_st_t;

    out_st_t  out_d, out_q;
    logic     eff_tick;
    logic     sec_wrap;
    logic     min_wrap;
    len_sel_e len_sel;

    assign eff_tick = osc_tick & ~osc_stop;

    rtc_raw_div #(
        .T32_DIV    (T32_DIV),
        .FTEST_HALF (FTEST_HALF)
    ) u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (eff_tick),
        .ftest_en   (ftest_en),
        .ftest_wave (ftest_wave),
        .tick32     (tick32)
    );

    rtc_sec_div #(
        .BASE_DIV   (BASE_DIV),
        .LONG_EXTRA (LONG_EXTRA),
        .SHORT_CUT  (SHORT_CUT)
    ) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (eff_tick),
        .len_sel  (len_sel),
        .sec_wrap (sec_wrap)
    );

    rtc_cal_cycle #(
        .SEC_PER_MIN (SEC_PER_MIN),
        .CAL_W       (CAL_W)
    ) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_wrap (sec_wrap),
        .cal_mag  (cal_mag),
        .cal_pos  (cal_pos),
        .len_sel  (len_sel),
        .min_wrap (min_wrap)
    );

    always_comb begin
        out_d.sec = sec_wrap;
        out_d.min = min_wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sec_tick = out_q.sec;
    assign min_tick = out_q.min;

    // R2: a minute marker always comes with a second pulse
    p_min_with_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);

    // R9: a stopped oscillator yields no pulses
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> (!sec_tick && !min_tick && !tick32));
endmodule

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;
    localparam int BASE = 128;
    localparam int LONG = 8;
    localparam int SHORT = 16;
    localparam int SPM = 2;
    localparam int CW = 5;
    localparam int FH = 4;
    localparam int T32 = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic osc_stop = 1'b0;
    logic [CW-1:0] cal_mag = '0;
    logic cal_pos = 1'b0;
    logic ftest_en = 1'b0;
    logic sec_tick, min_tick, ftest_wave, tick32;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    int total = 0;
    int since_sec = 0;
    int m_idx = 0;
    int s_idx = 0;
    int mag_b = 0;
    bit pos_b = 0;
    int minutes_seen = 0;
    int stop_secs = 0;

    rtc_trim_prescaler #(
        .BASE_DIV(BASE), .LONG_EXTRA(LONG), .SHORT_CUT(SHORT),
        .SEC_PER_MIN(SPM), .CAL_W(CW), .FTEST_HALF(FH), .T32_DIV(T32)
    ) u_rtc_trim_prescaler (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_stop(osc_stop),
        .cal_mag(cal_mag), .cal_pos(cal_pos), .ftest_en(ftest_en),
        .sec_tick(sec_tick), .min_tick(min_tick),
        .ftest_wave(ftest_wave), .tick32(tick32)
    );

    always #5 clk = ~clk;

    function automatic int exp_len(int m, int s, int mag, bit pos);
        if (s == 0 && m < 2 * mag) return pos ? BASE - SHORT : BASE + LONG;
        return BASE;
    endfunction

    function automatic string len_tag(int m, int s, int mag, bit pos);
        if (s == 0 && m < 2 * mag) return pos ? "R4" : "R3";
        if (mag > 0) return "R5";
        return "R2";
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one clock: check what the last edge produced, then drive new inputs
    task automatic observe();
        bit eff;
        int el;
        bit exp_sec;
        string tag;
        @(negedge clk);
        eff = osc_tick & ~osc_stop;
        if (eff) begin
            total++;
            since_sec++;
        end
        chk(tick32 == (eff && (total % T32 == 0)), "R8 tick32",
            int'(tick32), int'(eff && (total % T32 == 0)));
        chk(ftest_wave == (ftest_en & ((total / FH) % 2 == 1)), "R7 ftest_wave",
            int'(ftest_wave), int'(ftest_en & ((total / FH) % 2 == 1)));
        el = exp_len(m_idx, s_idx, mag_b, pos_b);
        exp_sec = eff && (since_sec == el);
        tag = len_tag(m_idx, s_idx, mag_b, pos_b);
        if (int'(cal_mag) != mag_b || cal_pos != pos_b) tag = {"R6/", tag};
        if (osc_stop) tag = {"R9/", tag};
        if (sec_tick || exp_sec)
            chk(sec_tick == exp_sec, {tag, " second length"}, since_sec, el);
        if (min_tick && !exp_sec)
            chk(1'b0, "R2 stray min_tick", 1, 0);
        if (exp_sec) begin
            since_sec = 0;
            chk(min_tick == (s_idx == SPM - 1), "R2 min_tick",
                int'(min_tick), int'(s_idx == SPM - 1));
            if (s_idx == SPM - 1) begin
                s_idx = 0;
                m_idx = (m_idx + 1) % 64;
                minutes_seen++;
                mag_b = int'(cal_mag);
                pos_b = cal_pos;
            end else begin
                s_idx++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            chk(!sec_tick && !min_tick && !tick32 && !ftest_wave, "R1 reset outputs",
                int'({sec_tick, min_tick, tick32, ftest_wave}), 0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            observe();
            chk(!sec_tick && !min_tick && !tick32 && !ftest_wave, "R1 idle after reset",
                int'({sec_tick, min_tick, tick32, ftest_wave}), 0);
        end

        // Phase 1: full positive trim, over a 64-minute wrap (R4, R5)
        cal_mag = 5'd31; cal_pos = 1'b1; ftest_en = 1'b1;
        while (minutes_seen < 70) begin
            observe();
            osc_tick = ($urandom % 8) != 0;
        end

        // Phase 2: small negative trim set in mid-minute (R3, R6)
        repeat (37) begin
            observe();
            osc_tick = 1'b1;
        end
        cal_mag = 5'd3; cal_pos = 1'b0;
        while (minutes_seen < 140) begin
            observe();
            osc_tick = ($urandom % 8) != 0;
        end

        // Phase 3: random mix of trim, stops, gaps and test enable
        for (int c = 0; c < 45000; c++) begin
            observe();
            osc_tick = ($urandom % 4) != 0;
            if (($urandom % 1500) == 0) begin
                cal_mag = CW'($urandom % 32);
                cal_pos = $urandom % 2;
            end
            if (osc_stop) begin
                if (($urandom % 40) == 0) osc_stop = 1'b0;
            end else if (($urandom % 700) == 0) osc_stop = 1'b1;
            if (($urandom % 500) == 0) ftest_en = ~ftest_en;
        end

        // Phase 4: directed stop, longer than any second (R9)
        osc_stop = 1'b1; osc_tick = 1'b1; ftest_en = 1'b1;
        repeat (2) observe();
        for (int c = 0; c < 400; c++) begin
            observe();
            if (sec_tick || tick32 || min_tick) stop_secs++;
        end
        chk(stop_secs == 0, "R9 pulses while stopped", stop_secs, 0);
        osc_stop = 1'b0;
        repeat (600) observe();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule